// File: doc/BRIEF.md
# 4-to-9 Horizontal Video Line Upsampler

This block takes one line of 4:2:2 video at a time and widens it by the ratio 9/4. A line of `IN_W` luma samples, each carried with one chroma byte (Cb on even positions, Cr on odd ones), becomes `OUT_W = IN_W*9/4` luma samples with interleaved chroma. With the default `IN_W = 320` this is 320 to 720 luma, and 160 to 360 samples for each chroma component. Only adjacent samples along the line are combined. There is no vertical filtering.

Each output position sits 4/9 of an input sample beyond the previous one. A phase counter that counts modulo 9 tracks this position. Luma is always blended linearly from its two neighbours using an 8-bit weight. Chroma is either repeated from the left neighbour or blended with a coarser 4-bit weight, as selected by a plain control pin. Two line banks separate the slow input stream (roughly 4.4 MHz of valid strobes) from the output stream. The output stream is pulled by its consumer at up to one sample per clock.

Both sides use valid/ready handshakes. A transfer happens on a clock edge where valid and ready are both high. The producer must hold its data stable while valid is high and ready is low. The block drops `in_ready` only when both line banks are full. It never withdraws `out_valid` or changes the output data before the transfer completes.

Top module: `upx_hscale`

## Requirements
- R1: An input line is exactly `IN_W` transfers. On transfer i, `in_c` carries Cb sample i/2 when i is even and Cr sample i/2 when i is odd.
- R2: Each stored line produces exactly `OUT_W = IN_W*9/4` output transfers. `out_last` is high on the final transfer and on no other.
- R3: For output j, let idx = floor(4j/9), p = 4j mod 9 and w = floor((256p+4)/9). Luma is (Y[idx]*(256-w) + Y[idx+1]*w + 128) >> 8, limited to the range 0..255.
- R4: At the right edge, any read past index `IN_W-1` uses sample `IN_W-1` instead, for both luma and chroma.
- R5: Output j carries Cb when j is even and Cr when j is odd. Both use chroma output index k = j/2.
- R6: When `chroma_lerp` is 0, the chroma output for index k is C[floor(4k/9)], where C is the component selected by R5.
- R7: When `chroma_lerp` is 1, let m = floor(4k/9), p = 4k mod 9 and v = floor((16p+4)/9). Chroma is (C[m]*(16-v) + C[m+1]*v + 8) >> 4.
- R8: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high and holds `out_y`, `out_c` and `out_last` unchanged.
- R9: Two lines can be buffered. `in_ready` is low exactly when both banks hold lines that have not yet been fully read. A new line is accepted while the previous line is still being output.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chroma_lerp | input | 1 | 0: repeat chroma, 1: blend chroma; hold stable across a line |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept an input sample |
| in_y | input | 8 | Input luma |
| in_c | input | 8 | Input chroma (Cb on even positions, Cr on odd) |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer accepts the output sample |
| out_y | output | 8 | Output luma |
| out_c | output | 8 | Output chroma (Cb on even outputs, Cr on odd) |
| out_last | output | 1 | Final sample of the output line |

## Verification
The bench builds the block with `IN_W = 16`, so each line has 36 luma outputs and 18 outputs per chroma component. With lines this short, every one of the nine phases and both right-edge clamps (luma index 15, chroma index 7) are reached many times in a few hundred cycles. The short lines also make it quick to fill both banks while the consumer stalls, which brings the full-buffer case into reach. Line contents include ramps, 0/255 alternation, constant full scale and random data. These are run in both chroma modes, with the consumer always ready, randomly ready and fully stalled.

// File: rtl/upx_pkg.sv
package upx_pkg;
  localparam int unsigned PIX_W = 8;

  // Fixed-point blend weight of the far neighbour for a given phase
  function automatic int unsigned phase_weight(input int unsigned p,
                                               input int unsigned frac,
                                               input int unsigned up);
    return (p * (32'd1 << frac) + up / 2) / up;
  endfunction
endpackage

// File: rtl/upx_phase.sv
// Tracks the fractional input position of the output stream:
// each step advances by DN/UP of an input sample.
module upx_phase #(
  parameter int unsigned LAST = 319,
  parameter int unsigned UP   = 9,
  parameter int unsigned DN   = 4,
  localparam int unsigned AW  = (LAST > 0) ? $clog2(LAST + 1) : 1,
  localparam int unsigned PW  = $clog2(UP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          clear,
  output logic [AW-1:0] idx,
  output logic [AW-1:0] idx_nxt,
  output logic [PW-1:0] phase
);
  localparam logic [AW-1:0] LAST_A = AW'(LAST);
  localparam logic [PW:0]   UP_P   = (PW+1)'(UP);
  localparam logic [PW:0]   DN_P   = (PW+1)'(DN);

  logic [AW-1:0] idx_q;
  logic [PW-1:0] ph_q;
  logic [PW:0]   ph_sum;
  logic          wrap;

  always_comb begin
    ph_sum = {1'b0, ph_q} + DN_P;
    wrap   = (ph_sum >= UP_P);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      idx_q <= '0;
      ph_q  <= '0;
    end else if (step) begin
      if (wrap) begin
        ph_q <= PW'(ph_sum - UP_P);
        if (idx_q != LAST_A) idx_q <= idx_q + 1'b1;
      end else begin
        ph_q <= PW'(ph_sum);
      end
    end
  end

  assign idx     = idx_q;
  assign idx_nxt = (idx_q == LAST_A) ? LAST_A : idx_q + 1'b1;
  assign phase   = ph_q;
endmodule

// File: rtl/upx_blend.sv
// Two-tap linear blend with FRAC-bit phase weight, rounded and saturated.
module upx_blend
  import upx_pkg::*;
#(
  parameter int unsigned FRAC = 8,
  parameter int unsigned UP   = 9,
  localparam int unsigned PW  = $clog2(UP),
  localparam int unsigned ACW = PIX_W + FRAC + 2
) (
  input  logic [PIX_W-1:0] near_s,
  input  logic [PIX_W-1:0] far_s,
  input  logic [PW-1:0]    phase,
  output logic [PIX_W-1:0] result
);
  localparam logic [ACW-1:0] ONE  = ACW'(1) << FRAC;
  localparam logic [ACW-1:0] HALF = ACW'(1) << (FRAC - 1);
  localparam logic [ACW-1:0] MAXV = ACW'((1 << PIX_W) - 1);

  logic [ACW-1:0] w;
  logic [ACW-1:0] acc;
  logic [ACW-1:0] shifted;

  always_comb begin
    w       = ACW'(phase_weight(32'(phase), FRAC, UP));
    acc     = ACW'(near_s) * (ONE - w) + ACW'(far_s) * w + HALF;
    shifted = acc >> FRAC;
    result  = (shifted > MAXV) ? '1 : PIX_W'(shifted);
  end
endmodule

// File: rtl/upx_line_store.sv
// Two banks of line storage: luma at full rate, Cb and Cr at half rate.
module upx_line_store
  import upx_pkg::*;
#(
  parameter int unsigned DEPTH = 320,
  localparam int unsigned CDEP = DEPTH / 2,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CAW  = $clog2(CDEP)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             wr_bank,
  input  logic [AW-1:0]    wr_addr,
  input  logic [PIX_W-1:0] wr_y,
  input  logic [PIX_W-1:0] wr_c,
  input  logic             rd_bank,
  input  logic [AW-1:0]    ya0,
  input  logic [AW-1:0]    ya1,
  input  logic [CAW-1:0]   ca0,
  input  logic [CAW-1:0]   ca1,
  output logic [PIX_W-1:0] y0,
  output logic [PIX_W-1:0] y1,
  output logic [PIX_W-1:0] cb0,
  output logic [PIX_W-1:0] cb1,
  output logic [PIX_W-1:0] cr0,
  output logic [PIX_W-1:0] cr1
);
  logic [PIX_W-1:0] ymem  [2][DEPTH];
  logic [PIX_W-1:0] cbmem [2][CDEP];
  logic [PIX_W-1:0] crmem [2][CDEP];

  logic [CAW-1:0] wr_caddr;
  assign wr_caddr = CAW'(wr_addr >> 1);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b))) begin
        ymem[b][wr_addr] <= wr_y;
        if (wr_addr[0]) crmem[b][wr_caddr] <= wr_c;
        else            cbmem[b][wr_caddr] <= wr_c;
      end
    end
  end

  assign y0  = ymem[rd_bank][ya0];
  assign y1  = ymem[rd_bank][ya1];
  assign cb0 = cbmem[rd_bank][ca0];
  assign cb1 = cbmem[rd_bank][ca1];
  assign cr0 = crmem[rd_bank][ca0];
  assign cr1 = crmem[rd_bank][ca1];
endmodule

// File: rtl/upx_hscale.sv
module upx_hscale
  import upx_pkg::*;
#(
  parameter int unsigned IN_W  = 320,
  parameter int unsigned UP    = 9,
  parameter int unsigned DN    = 4,
  parameter int unsigned YFRAC = 8,
  parameter int unsigned CFRAC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chroma_lerp,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_y,
  input  logic [PIX_W-1:0] in_c,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_y,
  output logic [PIX_W-1:0] out_c,
  output logic             out_last
);
  localparam int unsigned OUT_W = IN_W * UP / DN;
  localparam int unsigned CH_IN = IN_W / 2;
  localparam int unsigned AW    = $clog2(IN_W);
  localparam int unsigned CAW   = $clog2(CH_IN);
  localparam int unsigned OW    = $clog2(OUT_W);
  localparam int unsigned PW    = $clog2(UP);

  // ---------------- write side ----------------
  logic          wbank_q, rbank_q;
  logic [AW-1:0] wcnt_q;
  logic [1:0]    full_q;
  logic          wr_fire, wr_line_end;

  assign in_ready    = !full_q[wbank_q];
  assign wr_fire     = in_valid && in_ready;
  assign wr_line_end = wr_fire && (wcnt_q == AW'(IN_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt_q  <= '0;
      wbank_q <= 1'b0;
    end else if (wr_fire) begin
      if (wr_line_end) begin
        wcnt_q  <= '0;
        wbank_q <= ~wbank_q;
      end else begin
        wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end

  // ---------------- read side ----------------
  logic [OW-1:0] ocnt_q;
  logic          rd_load, rd_line_end, c_step;

  assign rd_load     = full_q[rbank_q] && (!out_valid || out_ready);
  assign rd_line_end = rd_load && (ocnt_q == OW'(OUT_W - 1));
  assign c_step      = rd_load && ocnt_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ocnt_q  <= '0;
      rbank_q <= 1'b0;
    end else if (rd_load) begin
      if (rd_line_end) begin
        ocnt_q  <= '0;
        rbank_q <= ~rbank_q;
      end else begin
        ocnt_q <= ocnt_q + 1'b1;
      end
    end
  end

  // bank occupancy: a bank is set by its last write and cleared by its last read
  logic [1:0] set_m, clr_m;
  always_comb begin
    set_m = '0;
    clr_m = '0;
    if (wr_line_end) set_m[wbank_q] = 1'b1;
    if (rd_line_end) clr_m[rbank_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) full_q <= '0;
    else        full_q <= (full_q & ~clr_m) | set_m;
  end

  // ---------------- position tracking ----------------
  logic [AW-1:0]  y_idx, y_nxt;
  logic [PW-1:0]  y_ph;
  logic [CAW-1:0] c_idx, c_nxt;
  logic [PW-1:0]  c_ph;

  upx_phase #(.LAST(IN_W - 1), .UP(UP), .DN(DN)) u_yphase (
    .clk(clk), .rst_n(rst_n), .step(rd_load), .clear(rd_line_end),
    .idx(y_idx), .idx_nxt(y_nxt), .phase(y_ph)
  );

  upx_phase #(.LAST(CH_IN - 1), .UP(UP), .DN(DN)) u_cphase (
    .clk(clk), .rst_n(rst_n), .step(c_step), .clear(rd_line_end),
    .idx(c_idx), .idx_nxt(c_nxt), .phase(c_ph)
  );

  // ---------------- storage ----------------
  logic [PIX_W-1:0] y0, y1, cb0, cb1, cr0, cr1;

  upx_line_store #(.DEPTH(IN_W)) u_store (
    .clk(clk), .wr_en(wr_fire), .wr_bank(wbank_q), .wr_addr(wcnt_q),
    .wr_y(in_y), .wr_c(in_c), .rd_bank(rbank_q),
    .ya0(y_idx), .ya1(y_nxt), .ca0(c_idx), .ca1(c_nxt),
    .y0(y0), .y1(y1), .cb0(cb0), .cb1(cb1), .cr0(cr0), .cr1(cr1)
  );

  // ---------------- arithmetic ----------------
  logic [PIX_W-1:0] y_res, c_near, c_far, c_lerp, c_res;

  upx_blend #(.FRAC(YFRAC), .UP(UP)) u_yblend (
    .near_s(y0), .far_s(y1), .phase(y_ph), .result(y_res)
  );

  assign c_near = ocnt_q[0] ? cr0 : cb0;
  assign c_far  = ocnt_q[0] ? cr1 : cb1;

  upx_blend #(.FRAC(CFRAC), .UP(UP)) u_cblend (
    .near_s(c_near), .far_s(c_far), .phase(c_ph), .result(c_lerp)
  );

  assign c_res = chroma_lerp ? c_lerp : c_near;

  // ---------------- output register ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_y     <= '0;
      out_c     <= '0;
      out_last  <= 1'b0;
    end else if (rd_load) begin
      out_valid <= 1'b1;
      out_y     <= y_res;
      out_c     <= c_res;
      out_last  <= rd_line_end;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/upx_hscale_chk.sv
module upx_hscale_chk #(
  parameter int unsigned OUT_W = 720,
  localparam int unsigned OW   = $clog2(OUT_W)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_y,
  input logic [7:0] out_c,
  input logic       out_last,
  input logic [1:0] full
);
  logic [OW-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= '0;
    else if (out_valid && out_ready)
      seen_q <= (seen_q == OW'(OUT_W - 1)) ? '0 : seen_q + 1'b1;
  end

  // R2: end marker only at the final position of a line
  p_last_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (seen_q == OW'(OUT_W - 1)));

  // R2: final position always carries the end marker
  p_last_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen_q == OW'(OUT_W - 1)) |-> out_last);

  // R8: stalled output holds
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_y) && $stable(out_c) && $stable(out_last)));

  // R9: no write acceptance with both banks occupied
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&full) |-> !in_ready);

  // R9: with both banks empty input is accepted
  p_free_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full == 2'b00) |-> in_ready);
endmodule

bind upx_hscale upx_hscale_chk #(.OUT_W(IN_W * UP / DN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_y(out_y), .out_c(out_c), .out_last(out_last),
  .full(full_q)
);

// File: tb/upx_hscale_tb.sv
module upx_hscale_tb;
  localparam int IN_W  = 16;
  localparam int OUT_W = IN_W * 9 / 4;
  localparam int CH    = IN_W / 2;

  logic clk = 0, rst_n = 0, chroma_lerp = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0, out_last;
  logic [7:0] in_y = 0, in_c = 0, out_y, out_c;

  always #4 clk = ~clk;

  upx_hscale #(.IN_W(IN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .chroma_lerp(chroma_lerp),
    .in_valid(in_valid), .in_ready(in_ready), .in_y(in_y), .in_c(in_c),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_y(out_y), .out_c(out_c), .out_last(out_last)
  );

  int checks = 0, errors = 0, cycles = 0, rdy_mode = 0;
  int ey_q[$], ec_q[$], el_q[$], ej_q[$];
  int cur_y[IN_W], cur_c[IN_W];
  int cur_n = 0;
  int pat_y[IN_W], pat_c[IN_W];
  bit monitor_on = 0;
  bit prev_stall = 0;
  logic [7:0] prev_y, prev_c;
  logic prev_l;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected output line, computed from the requirement formulas
  task automatic build_expected();
    int cb[CH], cr[CH];
    for (int m = 0; m < CH; m++) begin
      cb[m] = cur_c[2*m];       // R1: even position carries Cb
      cr[m] = cur_c[2*m+1];     // R1: odd position carries Cr
    end
    for (int j = 0; j < OUT_W; j++) begin
      int idx, p, w, a, b, k, m, cp, v, ca, cbv, res;
      idx = (4*j) / 9; p = (4*j) % 9;
      a = cur_y[idx];
      b = cur_y[(idx + 1 > IN_W - 1) ? IN_W - 1 : idx + 1];  // R4 clamp
      w = (256*p + 4) / 9;
      res = (a*(256 - w) + b*w + 128) >> 8;
      if (res > 255) res = 255;
      ey_q.push_back(res);
      k = j / 2; m = (4*k) / 9; cp = (4*k) % 9;
      ca  = (j % 2 == 0) ? cb[m] : cr[m];
      cbv = (j % 2 == 0) ? cb[(m+1 > CH-1) ? CH-1 : m+1] : cr[(m+1 > CH-1) ? CH-1 : m+1];
      if (chroma_lerp) begin
        v = (16*cp + 4) / 9;
        ec_q.push_back((ca*(16 - v) + cbv*v + 8) >> 4);
      end else begin
        ec_q.push_back(ca);
      end
      el_q.push_back(j == OUT_W - 1);
      ej_q.push_back(j);
    end
  endtask

  // Monitor: output ready driven on the falling edge, everything sampled 2 ns later
  always @(negedge clk) begin
    case (rdy_mode)
      0: out_ready = 1;
      1: out_ready = ($urandom % 3) != 0;
      default: out_ready = 0;
    endcase
    #2;
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (monitor_on) begin
      if (prev_stall) begin
        check("R8 valid held", int'(out_valid), 1);
        check("R8 luma held", int'(out_y), int'(prev_y));
        check("R8 chroma held", int'(out_c), int'(prev_c));
        check("R8 last held", int'(out_last), int'(prev_l));
      end
      prev_stall = out_valid && !out_ready;
      prev_y = out_y; prev_c = out_c; prev_l = out_last;
      if (in_valid && in_ready) begin   // R1 input transfer
        cur_y[cur_n] = in_y; cur_c[cur_n] = in_c;
        cur_n++;
        if (cur_n == IN_W) begin
          build_expected();
          cur_n = 0;
        end
      end
      if (out_valid && out_ready) begin
        if (ey_q.size() == 0) begin
          check("R2 unexpected output", 1, 0);
        end else begin
          int j;
          j = ej_q.pop_front();
          check((j >= OUT_W - 3) ? "R4 luma edge" : "R3 luma", int'(out_y), ey_q.pop_front());
          check(chroma_lerp ? "R5/R7 chroma" : "R5/R6 chroma", int'(out_c), ec_q.pop_front());
          check("R2 last flag", int'(out_last), el_q.pop_front());
        end
      end
    end
  end

  task automatic send_line(input int gap);
    for (int i = 0; i < IN_W; i++) begin
      bit acc;
      in_valid = 1; in_y = 8'(pat_y[i]); in_c = 8'(pat_c[i]);
      acc = 0;
      while (!acc) begin
        #1 acc = in_ready;
        @(negedge clk);
      end
      in_valid = 0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  task automatic drain();
    while (ey_q.size() != 0 || out_valid) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R10 out_valid after reset", int'(out_valid), 0);
    check("R10 in_ready after reset", int'(in_ready), 1);
    @(negedge clk);
    monitor_on = 1;

    // Chroma repetition, consumer always ready
    chroma_lerp = 0; rdy_mode = 0;
    for (int i = 0; i < IN_W; i++) begin pat_y[i] = i * 17; pat_c[i] = 255 - i * 13; end
    send_line(1);
    for (int i = 0; i < IN_W; i++) begin pat_y[i] = (i % 2) ? 255 : 0; pat_c[i] = (i % 4 < 2) ? 0 : 255; end
    send_line(0);
    for (int i = 0; i < IN_W; i++) begin pat_y[i] = $urandom % 256; pat_c[i] = $urandom % 256; end
    send_line(2);
    drain();

    // Chroma blending, consumer randomly ready
    chroma_lerp = 1; rdy_mode = 1;
    for (int i = 0; i < IN_W; i++) begin pat_y[i] = $urandom % 256; pat_c[i] = $urandom % 256; end
    send_line(0);
    for (int i = 0; i < IN_W; i++) begin pat_y[i] = 255; pat_c[i] = (i >= IN_W - 2) ? 0 : 255; end
    send_line(1);
    for (int i = 0; i < IN_W; i++) begin pat_y[i] = (i < IN_W/2) ? 10 : 240; pat_c[i] = (i < IN_W/2) ? 200 : 30; end
    send_line(0);
    drain();

    // R9: stall the consumer, fill both banks
    rdy_mode = 2;
    for (int i = 0; i < IN_W; i++) begin pat_y[i] = 3 * i; pat_c[i] = 128 + i; end
    send_line(0);
    for (int i = 0; i < IN_W; i++) begin pat_y[i] = 250 - 5 * i; pat_c[i] = 7 * i; end
    send_line(0);
    repeat (4) @(negedge clk);
    #1;
    check("R9 in_ready low with both banks full", int'(in_ready), 0);
    check("R9 output waiting", int'(out_valid), 1);
    rdy_mode = 0;
    drain();
    #1;
    check("R9 in_ready back after drain", int'(in_ready), 1);
    check("R2 all expected outputs seen", ey_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule